// File: doc/BRIEF.md
# Packed Shift, Align and Pack Unit

This block is a 32-bit datapath stage that reshapes one or two source words in a single pass. It shifts packed sub-word lanes to the right: four signed bytes move arithmetically, with optional rounding, and two unsigned halfwords move logically. It also narrows two signed words into two halfwords after an arithmetic shift, with the same rounding option. Finally it merges two words in four ways: byte-select packing, append, prepend and byte alignment.

The issuing stage presents an operation code, a 5-bit amount, a rounding enable and two operands `a` and `b` together with `in_valid`. The answer appears on `result` one clock later, with `result_valid` high for that cycle. For the merge operations `a` is the destination word that gets shifted, and `b` is the word that supplies the fill bits. When the amount comes from a register, the caller can pass the whole register field unmasked, because each lane operation reads only as many low bits as its lane needs.

Top module: `ppk_shift_pack`

## Requirements
- R1: With op 0 each byte lane of `a` is shifted right arithmetically (sign-filling) by `amount[2:0]`. A shift of 0 returns the lane unchanged, even when rounding is enabled.
- R2: With op 0, `rnd_en` high and a nonzero shift s, each byte lane becomes (lane >>> s) + bit (s-1) of the original lane, wrapping modulo 256.
- R3: With op 1 each 16-bit lane of `a` is shifted right logically (zero-filling) by `amount[3:0]`, and `rnd_en` has no effect.
- R4: Bits of `amount` above bit 2 (op 0) and above bit 3 (op 1) do not change the result.
- R5: With op 2 both `a` and `b` are shifted right arithmetically as signed 32-bit words by `amount[4:0]`, and rounded as in R2 when `rnd_en` is high. The low 16 bits of the shifted `a` form result[31:16] and the low 16 bits of the shifted `b` form result[15:0].
- R6: With op 3 the result is {a[23:16], a[7:0], b[23:16], b[7:0]}.
- R7: With op 4 and sa = `amount`, the result is (a << sa) with its low sa bits taken from the low sa bits of `b`. An sa of 0 returns `a`.
- R8: With op 5 and a nonzero sa, the result is (a >> sa) with its top sa bits taken from the low sa bits of `b`. An sa of 0 returns `a`.
- R9: With op 6 and bp = `amount[1:0]` nonzero, the result is (a << 8·bp) with its low bp bytes filled from the top bp bytes of `b`. A bp of 0 returns `a`.
- R10: Op codes 7 to 15 produce a result of zero.
- R11: `result` and `result_valid` update on the clock edge after `in_valid` is sampled high. When `in_valid` is low, `result_valid` goes low on that edge and `result` holds its value.
- R12: A synchronous active-low reset clears `result` and `result_valid` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Operation code (0 to 6 defined) |
| amount | input | 5 | Shift amount, sa or byte count |
| rnd_en | input | 1 | Rounding enable for ops 0 and 2 |
| a | input | 32 | Destination or first source word |
| b | input | 32 | Fill or second source word |
| result | output | 32 | Registered result |
| result_valid | output | 1 | High one cycle after an accepted operation |

## Verification
The properties assume that `op`, `amount`, `a` and `b` carry known values whenever `in_valid` is high. They also assume these inputs stay steady around the sampling edge, because the properties compare `result` against the `$past` of those inputs. The bench changes every input only at the falling clock edge, and it always drives defined values, including during reset and during idle cycles. It also changes the operands during idle cycles, so that the hold property sees operand activity while `in_valid` is low.

// File: rtl/ppk_pkg.sv
// Shared definitions for the packed shift/pack unit.
// Assumes a 4-bit operation code and that all undefined codes produce zero.
package ppk_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_SHRA_B  = 4'd0,
        OP_SHRL_H  = 4'd1,
        OP_NARROW  = 4'd2,
        OP_PACK    = 4'd3,
        OP_APPEND  = 4'd4,
        OP_PREPEND = 4'd5,
        OP_ALIGN   = 4'd6
    } ppk_op_e;
endpackage

// File: rtl/ppk_lane_shift.sv
// Lane-parallel right shifter.
// Splits the source into DATA_W/LANE_W lanes and shifts each lane right by the
// same amount. ARITH selects a sign-filling or a zero-filling shift. When rnd
// is set and the shift is nonzero, the last bit shifted out is added back
// (the sum wraps within the lane). Assumes LANE_W is a power of two.
module ppk_lane_shift #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    parameter bit ARITH  = 1'b1,
    parameter int SH_W   = $clog2(LANE_W)
) (
    input  logic [DATA_W-1:0] src,
    input  logic [SH_W-1:0]   sh,
    input  logic              rnd,
    output logic [DATA_W-1:0] dst
);
    localparam int NLANE = DATA_W / LANE_W;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [LANE_W-1:0] lane;
        logic [LANE_W-1:0] shifted;
        logic [SH_W-1:0]   sh_m1;
        logic              rbit;

        assign lane  = src[g*LANE_W +: LANE_W];
        assign sh_m1 = sh - 1'b1;

        if (ARITH) begin : g_arith
            // sign-filling shift of one lane
            assign shifted = $signed(lane) >>> sh;
        end else begin : g_logic
            // zero-filling shift of one lane
            assign shifted = lane >> sh;
        end

        // round bit: last bit shifted out, only for a nonzero shift
        assign rbit = rnd && (sh != '0) && lane[sh_m1];
        assign dst[g*LANE_W +: LANE_W] = shifted + {{(LANE_W-1){1'b0}}, rbit};
    end
endmodule

// File: rtl/ppk_merge.sv
// Two-word merge unit: byte-select pack, append, prepend and byte align.
// a is the destination word and b supplies the fill bits. Any op code not
// handled here yields zero. Assumes DATA_W is a multiple of 16.
module ppk_merge
    import ppk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [OP_W-1:0]   op,
    input  logic [AMT_W-1:0]  amt,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] dst
);
    localparam int HALF   = DATA_W / 2;
    localparam int NHALF  = DATA_W / 16;
    localparam int NBYTE  = DATA_W / 8;
    localparam int BP_W   = $clog2(NBYTE);

    logic [DATA_W-1:0] packed_w;
    logic [DATA_W-1:0] fill_mask;
    logic [DATA_W-1:0] app_w;
    logic [DATA_W-1:0] pre_w;
    logic [DATA_W-1:0] aln_w;
    logic [BP_W-1:0]   bp;
    logic [AMT_W:0]    pre_left;

    // pack: low byte of every halfword, a in the upper half, b in the lower
    for (genvar h = 0; h < NHALF; h++) begin : g_pack
        assign packed_w[HALF + h*8 +: 8] = a[h*16 +: 8];
        assign packed_w[h*8 +: 8]        = b[h*16 +: 8];
    end

    assign fill_mask = ~({DATA_W{1'b1}} << amt);
    assign pre_left  = (AMT_W+1)'(DATA_W) - {1'b0, amt};
    assign bp        = amt[BP_W-1:0];

    // append: shift a left, fill low bits from b
    always_comb app_w = (a << amt) | (b & fill_mask);

    // prepend: shift a right, fill top bits from b
    always_comb pre_w = (amt == '0) ? a : ((b << pre_left) | (a >> amt));

    // align: shift a left by whole bytes, fill from the top bytes of b
    always_comb aln_w = (bp == '0) ? a
                      : ((a << (8 * int'(bp))) | (b >> (DATA_W - 8 * int'(bp))));

    // result select for the merge group
    always_comb begin
        case (op)
            OP_PACK:    dst = packed_w;
            OP_APPEND:  dst = app_w;
            OP_PREPEND: dst = pre_w;
            OP_ALIGN:   dst = aln_w;
            default:    dst = '0;
        endcase
    end
endmodule

// File: rtl/ppk_shift_pack.sv
// Top of the packed shift/pack unit.
// Runs all operation groups in parallel, selects one by op and registers the
// answer one clock after in_valid. result holds while in_valid is low.
// Assumes inputs are stable and known at the sampling edge when in_valid is high.
module ppk_shift_pack
    import ppk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [AMT_W-1:0]  amount,
    input  logic              rnd_en,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result,
    output logic              result_valid
);
    localparam int BSH_W = $clog2(8);
    localparam int HSH_W = $clog2(16);
    localparam int HALF  = DATA_W / 2;

    logic [DATA_W-1:0]   byte_res;
    logic [DATA_W-1:0]   half_res;
    logic [2*DATA_W-1:0] word_sh;
    logic [DATA_W-1:0]   narrow_res;
    logic [DATA_W-1:0]   merge_res;
    logic [DATA_W-1:0]   next_res;

    ppk_lane_shift #(.DATA_W(DATA_W), .LANE_W(8), .ARITH(1'b1)) u_byte (
        .src(a), .sh(amount[BSH_W-1:0]), .rnd(rnd_en), .dst(byte_res)
    );

    ppk_lane_shift #(.DATA_W(DATA_W), .LANE_W(16), .ARITH(1'b0)) u_half (
        .src(a), .sh(amount[HSH_W-1:0]), .rnd(1'b0), .dst(half_res)
    );

    ppk_lane_shift #(.DATA_W(2*DATA_W), .LANE_W(DATA_W), .ARITH(1'b1)) u_word (
        .src({a, b}), .sh(amount), .rnd(rnd_en), .dst(word_sh)
    );

    assign narrow_res = {word_sh[DATA_W +: HALF], word_sh[0 +: HALF]};

    ppk_merge #(.DATA_W(DATA_W)) u_merge (
        .op(op), .amt(amount), .a(a), .b(b), .dst(merge_res)
    );

    // pick the answer for the current op
    always_comb begin
        case (op)
            OP_SHRA_B: next_res = byte_res;
            OP_SHRL_H: next_res = half_res;
            OP_NARROW: next_res = narrow_res;
            default:   next_res = merge_res;
        endcase
    end

    // output register with hold on idle cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= in_valid;
            if (in_valid) result <= next_res;
        end
    end
endmodule

// File: rtl/ppk_shift_pack_chk.sv
// Property checker for ppk_shift_pack, bound to every instance of the top.
module ppk_shift_pack_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  op,
    input logic [4:0]  amount,
    input logic        rnd_en,
    input logic [31:0] a,
    input logic [31:0] b,
    input logic [31:0] result,
    input logic        result_valid
);
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> result_valid);
    a_r11_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !result_valid);
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    a_r10_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= 4'd7) |=> (result == 32'd0));
    a_r1_zero_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd0 && amount[2:0] == 3'd0) |=> (result == $past(a)));
    a_r3_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd1 && amount[3:0] != 4'd0) |=> (!result[31] && !result[15]));
    a_r6_pack_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd3) |=> (result[31:24] == $past(a[23:16]) && result[7:0] == $past(b[7:0])));
    a_r8_prepend_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd5 && amount == 5'd0) |=> (result == $past(a)));
    a_r9_align_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd6 && amount[1:0] == 2'd0) |=> (result == $past(a)));
    a_r12_reset: assert property (@(posedge clk)
        !rst_n |=> (result == 32'd0 && !result_valid));
endmodule

bind ppk_shift_pack ppk_shift_pack_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .amount(amount),
    .rnd_en(rnd_en), .a(a), .b(b), .result(result), .result_valid(result_valid)
);

// File: tb/sim_ppk_shift_pack.sv
module sim_ppk_shift_pack;
    typedef struct packed {
        logic [3:0]  op;
        logic [4:0]  amt;
        logic        rnd;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 5'd2,  1'b0, 32'h807FF010, 32'h0,        32'hE01FFC04, 8'd1},  // R1
        '{4'd0, 5'd0,  1'b1, 32'h12345678, 32'h0,        32'h12345678, 8'd1},  // R1 zero shift
        '{4'd0, 5'd1,  1'b1, 32'h7F810302, 32'h0,        32'h40C10201, 8'd2},  // R2
        '{4'd0, 5'd7,  1'b1, 32'hC040807F, 32'h0,        32'h0001FF01, 8'd2},  // R2 max shift
        '{4'd0, 5'd26, 1'b0, 32'h807FF010, 32'h0,        32'hE01FFC04, 8'd4},  // R4 byte mask
        '{4'd1, 5'd4,  1'b0, 32'hF00F8001, 32'h0,        32'h0F000800, 8'd3},  // R3
        '{4'd1, 5'd15, 1'b0, 32'h80007FFF, 32'h0,        32'h00010000, 8'd3},  // R3 max
        '{4'd1, 5'd1,  1'b1, 32'h00030003, 32'h0,        32'h00010001, 8'd3},  // R3 no rounding
        '{4'd1, 5'd19, 1'b0, 32'h80000010, 32'h0,        32'h10000002, 8'd4},  // R4 half mask
        '{4'd2, 5'd16, 1'b0, 32'h12345678, 32'hFFFF8000, 32'h1234FFFF, 8'd5},  // R5
        '{4'd2, 5'd16, 1'b1, 32'h12345678, 32'hFFFF8000, 32'h12340000, 8'd5},  // R5 round
        '{4'd2, 5'd0,  1'b1, 32'hAAAA1111, 32'h5555BEEF, 32'h1111BEEF, 8'd5},  // R5 zero
        '{4'd2, 5'd31, 1'b1, 32'hC0000000, 32'h40000000, 32'h00000001, 8'd5},  // R5 max
        '{4'd3, 5'd0,  1'b0, 32'h11223344, 32'hAABBCCDD, 32'h2244BBDD, 8'd6},  // R6
        '{4'd4, 5'd8,  1'b0, 32'h11223344, 32'hAABBCCDD, 32'h223344DD, 8'd7},  // R7
        '{4'd4, 5'd0,  1'b0, 32'h11223344, 32'hAABBCCDD, 32'h11223344, 8'd7},  // R7 zero
        '{4'd4, 5'd31, 1'b0, 32'h00000001, 32'hFFFFFFFE, 32'hFFFFFFFE, 8'd7},  // R7 max
        '{4'd5, 5'd8,  1'b0, 32'h11223344, 32'hAABBCCDD, 32'hDD112233, 8'd8},  // R8
        '{4'd5, 5'd0,  1'b0, 32'h11223344, 32'hAABBCCDD, 32'h11223344, 8'd8},  // R8 zero
        '{4'd5, 5'd1,  1'b0, 32'h00000002, 32'h00000001, 32'h80000001, 8'd8},  // R8 one
        '{4'd6, 5'd1,  1'b0, 32'h11223344, 32'hAABBCCDD, 32'h223344AA, 8'd9},  // R9
        '{4'd6, 5'd3,  1'b0, 32'h11223344, 32'hAABBCCDD, 32'h44AABBCC, 8'd9},  // R9 max
        '{4'd6, 5'd0,  1'b0, 32'h11223344, 32'hAABBCCDD, 32'h11223344, 8'd9},  // R9 zero
        '{4'd6, 5'd6,  1'b0, 32'h11223344, 32'hAABBCCDD, 32'h3344AABB, 8'd9},  // R9 low bits only
        '{4'd7, 5'd3,  1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 8'd10}, // R10
        '{4'd15,5'd9,  1'b1, 32'h12345678, 32'h9ABCDEF0, 32'h00000000, 8'd10}  // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [4:0]  amount = '0;
    logic        rnd_en = 1'b0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [31:0] result;
    logic        result_valid;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    ppk_shift_pack u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .amount(amount),
        .rnd_en(rnd_en), .a(a), .b(b), .result(result), .result_valid(result_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // drive one operation at a falling edge, sample after the next rising edge
    task automatic run_op(input vec_t v);
        @(negedge clk);
        in_valid = 1'b1; op = v.op; amount = v.amt; rnd_en = v.rnd; a = v.a; b = v.b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset result", result, 32'h0);
        check("R12 reset valid", {31'h0, result_valid}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i]);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), result, VECS[i].exp);
            check("R11 valid after strobe", {31'h0, result_valid}, 32'h1);
        end

        // R11: idle cycle with new operands keeps result and drops valid
        @(negedge clk);
        a = 32'hDEADBEEF; b = 32'h01234567; op = 4'd3;
        check("R11 idle valid low", {31'h0, result_valid}, 32'h0);
        @(negedge clk);
        check("R11 result held", result, 32'h00000000);

        // R11: result held after a nonzero result
        run_op(VECS[13]);
        a = 32'h0; b = 32'h0;
        @(negedge clk);
        check("R11 hold nonzero", result, 32'h2244BBDD);

        // R12: reset in mid run clears the output
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        check("R12 mid reset result", result, 32'h0);
        check("R12 mid reset valid", {31'h0, result_valid}, 32'h0);
        in_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule